// File: doc/BRIEF.md
# Self-Synchronizing Parallel Scrambler / Descrambler (1 + x^39 + x^58)

This block scrambles or descrambles one 64-bit word per clock with the multiplicative polynomial 1 + x^39 + x^58. A 58-bit history holds the most recent bits of the scrambled-side stream. When the block scrambles, those are the bits it has just produced. When it descrambles, they are the bits it has just received. The scrambler state therefore follows the data, and there is no free-running generator. The history is a plain shift line with no XOR between its stages. XOR gates appear only where the two taps combine with the incoming bit.

Each word is handled as 64 consecutive serial bits, with bit 0 first. Because the 58-bit span is shorter than the word, the upper output bits of a scrambled word depend on lower output bits of the same word. Each word gives exactly the result that a serial, bit-at-a-time implementation gives for the same stream. A descrambler that starts from any history state produces correct data once 58 scrambled bits have passed through it, so the two ends need no shared seed. The mode is selected per word, and the result appears on a registered output one clock later.

Top module: `ss_scrambler`

## Requirements
- R1: With mode = 0 (scramble) and in_valid high, each output bit is out[i] = din[i] ^ s(i-39) ^ s(i-58). Here s is the scrambled stream, made of previous scrambled bits followed by the scrambled bits of the current word, taken in ascending bit order (bit 0 is the earliest).
- R2: With mode = 1 (descramble) and in_valid high, each output bit is out[i] = din[i] ^ r(i-39) ^ r(i-58). Here r is the received stream: earlier words' din followed by the current word's din, with bit 0 the earliest.
- R3: After each accepted word, the history holds the newest 58 bits of the scrambled-side stream. In scramble mode these are output bits 63..6 of that word. In descramble mode they are input bits 63..6. The mode may change between consecutive words.
- R4: While rst_n is low at a clock edge, the history clears to all zeros, dout becomes 0 and out_valid becomes 0. The next word is then processed as if every earlier stream bit were 0.
- R5: out_valid is high in the cycle after a clock edge where in_valid was high, and low after an edge where in_valid was low. dout shows the result of the word accepted at that edge.
- R6: A cycle with in_valid low changes neither the history nor dout. The next accepted word continues the stream as if the idle cycle had not occurred.
- R7: In descramble mode, whatever the starting history, every output bit that has at least 58 received bits before it in the stream equals the plain data that the far-end scrambler consumed.
- R8: Starting from a matched reset, descrambling the scrambled words returns the original words exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | din holds a word to process this cycle |
| mode | input | 1 | 0 = scramble, 1 = descramble |
| din | input | 64 | Input word, bit 0 earliest in the stream |
| dout | output | 64 | Registered result word |
| out_valid | output | 1 | dout holds a new result |

## Verification
The bench drives several kinds of input and compares every cycle against a serial bit-queue model. A single set bit in front of a zero history exposes the exact positions of both taps and shows the feedback crossing from one word into the next. All-zero words and all-one words show that a zero history stays at zero and that a constant input excites every tap. Random words with the mode switching from word to word separate the two ways the history is loaded. Idle gaps, resets in mid-stream, a descrambler whose history does not match the far end, and a scramble-then-descramble round trip cover the holding, clearing, self-synchronizing and inverse behaviour.

// File: rtl/ss_scr_pkg.sv
// Package: shared mode encoding for the self-synchronizing scrambler.
package ss_scr_pkg;

    // Operating mode; the encoding is visible on the top-level mode pin.
    typedef enum logic {
        MODE_SCRAMBLE   = 1'b0,
        MODE_DESCRAMBLE = 1'b1
    } scr_mode_e;

endpackage

// File: rtl/ss_feedback_core.sv
// Module: ss_feedback_core
// Purely combinational per-word transform. It treats the word as DATA_W
// serial bits, bit 0 first. Each bit is XORed with the stream bits TAP_NEAR
// and HIST_W positions back, and the scrambled-side bit is appended to the
// extended history. Scramble mode appends the result; descramble mode
// appends the input. Assumes 0 < TAP_NEAR < HIST_W.
module ss_feedback_core
    import ss_scr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int HIST_W   = 58,
    parameter int TAP_NEAR = 39
) (
    input  scr_mode_e          mode,
    input  logic [DATA_W-1:0]  din,
    input  logic [HIST_W-1:0]  hist,
    output logic [DATA_W-1:0]  dout_next,
    output logic [HIST_W-1:0]  hist_next
);
    localparam int TOTAL_W  = HIST_W + DATA_W;
    localparam int NEAR_OFF = HIST_W - TAP_NEAR;

    logic [TOTAL_W-1:0] ext;

    // Walk the word in stream order, extending the history one bit at a time.
    always_comb begin
        ext       = {{DATA_W{1'b0}}, hist};
        dout_next = '0;
        for (int i = 0; i < DATA_W; i++) begin
            logic res;
            res          = din[i] ^ ext[NEAR_OFF + i] ^ ext[i];
            dout_next[i] = res;
            ext[HIST_W + i] = (mode == MODE_DESCRAMBLE) ? din[i] : res;
        end
        hist_next = ext[TOTAL_W-1 -: HIST_W];
    end

endmodule

// File: rtl/ss_history_reg.sv
// Module: ss_history_reg
// Holds the newest HIST_W scrambled-side stream bits. It clears on a
// synchronous active-low reset and loads only when a word is accepted.
module ss_history_reg #(
    parameter int HIST_W = 58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HIST_W-1:0] d,
    output logic [HIST_W-1:0] q
);
    // History register: clear, load on an accepted word, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/ss_out_stage.sv
// Module: ss_out_stage
// Output register. It captures the transformed word on an accepted input
// and keeps the last result during idle cycles; out_valid marks new data.
module ss_out_stage #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] dout,
    output logic              out_valid
);
    // Data register: load on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (in_valid)
            dout <= d;
    end

    // Valid flag: one-cycle-delayed copy of in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

endmodule

// File: rtl/ss_scrambler.sv
// Module: ss_scrambler (top)
// Self-synchronizing multiplicative scrambler/descrambler for
// 1 + x^TAP_NEAR + x^HIST_W, processing DATA_W bits per clock with a
// one-cycle registered latency. mode selects scramble (0) or descramble (1)
// word by word. Assumes a synchronous active-low reset.
module ss_scrambler
    import ss_scr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int HIST_W   = 58,
    parameter int TAP_NEAR = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              out_valid
);
    scr_mode_e         mode_e;
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;
    logic [DATA_W-1:0] word_d;

    // Mode pin decode into the shared enum.
    always_comb mode_e = scr_mode_e'(mode);

    ss_feedback_core #(
        .DATA_W   (DATA_W),
        .HIST_W   (HIST_W),
        .TAP_NEAR (TAP_NEAR)
    ) u_core (
        .mode      (mode_e),
        .din       (din),
        .hist      (hist_q),
        .dout_next (word_d),
        .hist_next (hist_d)
    );

    ss_history_reg #(
        .HIST_W (HIST_W)
    ) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_valid),
        .d     (hist_d),
        .q     (hist_q)
    );

    ss_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (word_d),
        .dout      (dout),
        .out_valid (out_valid)
    );

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hist_q));

    // R6
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dout));

    // R4
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (hist_q == '0 && dout == '0 && !out_valid));

    // R3
    desc_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 1'b1) |=>
            hist_q == $past(din[DATA_W-1 -: HIST_W]));

    // The scramble-side history check needs the word to cover the span.
    generate
        if (DATA_W >= HIST_W) begin : g_scr_hist_chk
            // R3
            scr_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && mode == 1'b0) |=>
                    hist_q == dout[DATA_W-1 -: HIST_W]);
        end
    endgenerate

endmodule

// File: tb/ss_scrambler_tb.sv
// Bench: serial bit-queue reference model, compared on every clock.
module ss_scrambler_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [63:0] din = '0;
    logic [63:0] dout;
    logic        out_valid;

    int checks = 0;
    int errors = 0;

    bit          hq[$];      // model history, newest at the back
    bit          tq[$];      // independent far-end scrambler history
    logic [63:0] exp_dout  = '0;
    logic        exp_valid = 1'b0;

    logic [63:0] plain [0:15];
    logic [63:0] cipher[0:15];

    always #4 clk = ~clk;    // 125 MHz

    ss_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .din(din), .dout(dout), .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic void clear_model();
        hq.delete();
        for (int k = 0; k < 58; k++) hq.push_back(1'b0);
    endfunction

    // Serial model: one bit at a time, bit 0 first.
    function automatic logic [63:0] model_word(input logic m, input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            bit o;
            o = d[i] ^ hq[hq.size()-39] ^ hq[0];
            r[i] = o;
            hq.push_back(m ? d[i] : o);
            void'(hq.pop_front());
        end
        return r;
    endfunction

    // Far-end serial scrambler with its own history.
    function automatic logic [63:0] tx_word(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            bit o;
            o = d[i] ^ tq[tq.size()-39] ^ tq[0];
            r[i] = o;
            tq.push_back(o);
            void'(tq.pop_front());
        end
        return r;
    endfunction

    task automatic step(input logic v, input logic m, input logic [63:0] d);
        string tag;
        @(negedge clk);
        rst_n = 1'b1; in_valid = v; mode = m; din = d;
        if (v) begin
            exp_dout = model_word(m, d);
            exp_valid = 1'b1;
            tag = m ? "R2" : "R1";
        end else begin
            exp_valid = 1'b0;
            tag = "R6";
        end
        @(posedge clk); #2;
        check("R5 out_valid", {63'd0, out_valid}, {63'd0, exp_valid});
        check(tag, dout, exp_dout);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); #2;
        clear_model();
        exp_dout = '0; exp_valid = 1'b0;
        check("R4 dout", dout, 64'd0);
        check("R4 out_valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_model();
        do_reset();
        do_reset();

        // R1: zero words into zero history stay zero
        step(1'b1, 1'b0, 64'd0);
        check("R1 zero", dout, 64'd0);
        step(1'b1, 1'b0, 64'd0);

        // R1: single impulse shows both taps, in-word and across words
        do_reset();
        step(1'b1, 1'b0, 64'd1);
        check("R1 impulse", dout, 64'h0400_0080_0000_0001);
        step(1'b1, 1'b0, 64'd0);
        step(1'b1, 1'b0, 64'd0);

        // R6: idle cycles hold, then the stream continues
        step(1'b0, 1'b0, 64'hDEAD_BEEF_0000_FFFF);
        step(1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0);
        step(1'b1, 1'b0, 64'd0);

        // R1 R2 R3: random words, mode switching word to word
        for (int k = 0; k < 24; k++)
            step(1'b1, 1'($urandom_range(0, 1)), {$urandom, $urandom});

        // all-ones words in both modes
        step(1'b1, 1'b0, '1);
        step(1'b1, 1'b0, '1);
        step(1'b1, 1'b1, '1);
        step(1'b1, 1'b1, '1);

        // R8: round trip from matched reset, with a mid-run reset (R4)
        do_reset();
        for (int k = 0; k < 10; k++) begin
            plain[k] = {$urandom, $urandom};
            step(1'b1, 1'b0, plain[k]);
            cipher[k] = dout;
        end
        do_reset();
        for (int k = 0; k < 10; k++) begin
            step(1'b1, 1'b1, cipher[k]);
            check("R8 round trip", dout, plain[k]);
        end

        // R7: descrambler with unmatched history self-synchronizes
        tq.delete();
        for (int k = 0; k < 58; k++) tq.push_back(1'b1);
        for (int k = 0; k < 8; k++) begin
            plain[k]  = {$urandom, $urandom};
            cipher[k] = tx_word(plain[k]);
        end
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 1'b1, cipher[k]);
            if (k == 0)
                check("R7 first word tail", {58'd0, dout[63:58]}, {58'd0, plain[0][63:58]});
            else
                check("R7 synced", dout, plain[k]);
        end

        step(1'b0, 1'b0, 64'd0);
        finish_run();
    end

endmodule